// File: doc/BRIEF.md
# Center-Aligned PWM Generator

This block produces a single pulse-width-modulated output whose pulse sits in the middle of each PWM period. An internal counter runs upward from zero to one below the programmed period value and then back down to zero, so one PWM period lasts twice the period value in clock cycles. The output is asserted while the counter is within the programmed duty distance of its turning point. As a result, the high time equals twice the duty value, and it is centred on the turn.

Software programs the period and the duty value through a one-cycle write strobe. Each write lands in a shadow register. The active copies load only at defined update points, so the waveform cannot glitch in the middle of a period. A mode input selects one of two update policies:

- Single update: the active duty loads only at the period start, which gives symmetric pulses.
- Dual update: the active duty also loads at the turning point, so the two halves of one period can use different duty values and the pulse can be asymmetric.

Two one-cycle strobes mark the period start and the turning point. The write port is a plain control port with no handshake; it accepts a write on every cycle in which the strobe is high.

Top module: `pwm_center_gen`

## Requirements
- R1: One PWM period lasts 2*P clock cycles, where P is the active period value (a programmed 0 acts as 1). Number the cycles of a period i = 0 to 2P-1. The counter value is i in the first half (i < P) and 2P-1-i in the second half.
- R2: `pwm_out` is high exactly when the counter value is at least P-D, where D is the duty value active in that half. In single-update mode this gives high cycles P-D through P+D-1, which is symmetric about the turning point.
- R3: An active duty of 0 holds `pwm_out` low for that whole half.
- R4: An active duty greater than or equal to P holds `pwm_out` high for that whole half.
- R5: With `dual_update` low, a duty written during a period has no effect on that period. It first applies in both halves of the next period.
- R6: With `dual_update` high, a duty written at a clock edge before the turning-point edge of a period applies to the second half of that same period. The first half keeps the value loaded at the period start.
- R7: A period value written during a period takes effect only from the next period start.
- R8: `period_start` is high for one cycle in cycle 0 of each period. `period_mid` is high for one cycle in cycle P. The two strobes are never high together.
- R9: While `enable` is low, the counter is held at zero and all three outputs are low at the edge after `enable` is sampled low. The first edge that samples `enable` high begins cycle 0 of a new period.
- R10: After reset, all outputs are low, the shadow period is 1 and the shadow duty is 0.
- R11: A write with `wr_en` high stores `wr_data` into the shadow period when `wr_sel` is 0, or into the shadow duty when `wr_sel` is 1, at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the counter when high; holds it idle when low |
| dual_update | input | 1 | 1 = duty also reloads at the turning point |
| wr_en | input | 1 | Shadow register write strobe |
| wr_sel | input | 1 | 0 = period, 1 = duty |
| wr_data | input | CW | Value to write |
| pwm_out | output | 1 | Center-aligned PWM output |
| period_start | output | 1 | One-cycle strobe in cycle 0 of each period |
| period_mid | output | 1 | One-cycle strobe at the turning point (cycle P) |

## Verification
Every output comes from a register. It therefore reflects the state entered at the most recent edge: the edge that samples `enable` high shows `period_start` in the following cycle, and a write sampled at edge k can be used by the first update point at edge k+1 or later. The driver pushes one expected output triple for every edge, each computed from R1 and R2 using the period and per-half duty that the update rules predict. The monitor pops and compares one triple two nanoseconds after each rising edge. Every write is placed at least one edge before the update point meant to pick it up, and at least one full period after the point meant to ignore it.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  // write target selector on the register port
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_DUTY   = 1'b1
  } wsel_e;

  // counter direction
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] sh_per,
  output logic [CW-1:0] sh_duty
);
  localparam logic [CW-1:0] PER_RST = CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per  <= PER_RST;
      sh_duty <= '0;
    end else if (wr_en) begin
      if (wsel_e'(wr_sel) == SEL_PERIOD) sh_per  <= wr_data;
      else                               sh_duty <= wr_data;
    end
  end

  a_r11_duty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (sh_duty == $past(wr_data)));
  a_r11_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (sh_per == $past(wr_data)));
endmodule

// File: rtl/pwm_updown_counter.sv
`timescale 1ns/1ps
module pwm_updown_counter
  import pwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] sh_per,
  output logic          go_start,
  output logic          go_mid,
  output logic [CW-1:0] nxt_cnt,
  output logic [CW-1:0] nxt_per
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, per_q, per_eff, top;
  dir_e          dir_q, nxt_dir;
  logic          run_q;

  // a programmed zero period behaves as the shortest legal period
  assign per_eff = (sh_per == '0) ? ONE : sh_per;
  assign top     = per_q - ONE;

  always_comb begin
    go_start = en && (!run_q || (dir_q == DIR_DOWN && cnt_q == '0));
    go_mid   = en && !go_start && (dir_q == DIR_UP) && (cnt_q == top);
    nxt_cnt  = cnt_q;
    nxt_dir  = dir_q;
    nxt_per  = per_q;
    if (!en) begin
      nxt_cnt = '0;
      nxt_dir = DIR_UP;
    end else if (go_start) begin
      nxt_cnt = '0;
      nxt_dir = DIR_UP;
      nxt_per = per_eff;
    end else if (go_mid) begin
      nxt_dir = DIR_DOWN;
    end else if (dir_q == DIR_DOWN) begin
      nxt_cnt = cnt_q - ONE;
    end else begin
      nxt_cnt = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
      per_q <= ONE;
      run_q <= 1'b0;
    end else begin
      cnt_q <= nxt_cnt;
      dir_q <= nxt_dir;
      per_q <= nxt_per;
      run_q <= en;
    end
  end

  a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  a_r1_start_state: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> (cnt_q == '0 && dir_q == DIR_UP));
  a_r7_per_only_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(per_q) |-> $past(go_start));
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0 && dir_q == DIR_UP && !run_q));
endmodule

// File: rtl/pwm_duty_compare.sv
`timescale 1ns/1ps
module pwm_duty_compare #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbl,
  input  logic [CW-1:0] sh_duty,
  input  logic          go_start,
  input  logic          go_mid,
  input  logic [CW-1:0] nxt_cnt,
  input  logic [CW-1:0] nxt_per,
  output logic          pwm_q,
  output logic          start_q,
  output logic          mid_q
);
  logic [CW-1:0] act_duty, nxt_duty;
  logic          load, hi;

  assign load     = go_start || (go_mid && dbl);
  assign nxt_duty = load ? sh_duty : act_duty;
  // full duty saturates; otherwise compare against distance from the turn
  assign hi = en && ((nxt_duty >= nxt_per) || (nxt_cnt >= nxt_per - nxt_duty));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_duty <= '0;
      pwm_q    <= 1'b0;
      start_q  <= 1'b0;
      mid_q    <= 1'b0;
    end else begin
      act_duty <= nxt_duty;
      pwm_q    <= hi;
      start_q  <= go_start;
      mid_q    <= go_mid;
    end
  end

  a_r5_duty_update_points: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_duty) |-> ($past(go_start) || ($past(go_mid) && $past(dbl))));
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && mid_q));
  a_r8_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_q && !start_q && !mid_q));
endmodule

// File: rtl/pwm_center_gen.sv
`timescale 1ns/1ps
module pwm_center_gen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dual_update,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic          pwm_out,
  output logic          period_start,
  output logic          period_mid
);
  logic [CW-1:0] sh_per, sh_duty, nxt_cnt, nxt_per;
  logic          go_start, go_mid;

  pwm_shadow_regs #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sh_per(sh_per), .sh_duty(sh_duty)
  );

  pwm_updown_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(enable), .sh_per(sh_per),
    .go_start(go_start), .go_mid(go_mid), .nxt_cnt(nxt_cnt), .nxt_per(nxt_per)
  );

  pwm_duty_compare #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(enable), .dbl(dual_update),
    .sh_duty(sh_duty), .go_start(go_start), .go_mid(go_mid),
    .nxt_cnt(nxt_cnt), .nxt_per(nxt_per),
    .pwm_q(pwm_out), .start_q(period_start), .mid_q(period_mid)
  );
endmodule

// File: tb/test_pwm_center_gen.sv
`timescale 1ns/1ps
module test_pwm_center_gen;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          dual_update = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [CW-1:0] wr_data = '0;
  logic          pwm_out, period_start, period_mid;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  logic [2:0] q_val[$];   // {pwm, start, mid}
  string      q_tag[$];

  always #4 clk = ~clk;

  pwm_center_gen #(.CW(CW)) i_pwm_center_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dual_update(dual_update),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_start(period_start), .period_mid(period_mid)
  );

  // monitor: compare one expected triple per edge
  always @(posedge clk) begin
    #2;
    if (q_val.size() > 0) begin
      logic [2:0] e;
      string      t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      n_checks++;
      if ({pwm_out, period_start, period_mid} !== e) begin
        n_fails++;
        $display("FAIL %s: {pwm,start,mid} actual=%b expected=%b at %0t",
                 t, {pwm_out, period_start, period_mid}, e, $time);
      end
    end
  end

  task automatic push(input logic [2:0] v, input string t);
    q_val.push_back(v);
    q_tag.push_back(t);
  endtask

  // idle cycles (R9): outputs low; optional write on the first one
  task automatic idle(input int n, input bit w, input logic s, input int d);
    for (int i = 0; i < n; i++) begin
      wr_en   = w && (i == 0);
      wr_sel  = s;
      wr_data = CW'(d);
      push(3'b000, "R9");
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  // one full period with per-half duties a/b and an optional write at cycle wat
  task automatic period(input int p, input int a, input int b, input string t,
                        input int wat, input logic s, input int d);
    for (int i = 0; i < 2 * p; i++) begin
      int  c, dd;
      logic hv;
      c  = (i < p) ? i : 2 * p - 1 - i;   // R1 counter value
      dd = (i < p) ? a : b;
      hv = (dd >= p) || (c >= p - dd);     // R2, R3, R4
      wr_en   = (i == wat);
      wr_sel  = s;
      wr_data = CW'(d);
      push({hv, i == 0, i == p}, t);       // R8 strobes
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if ({pwm_out, period_start, period_mid} !== 3'b000) begin
      n_fails++;
      $display("FAIL R10: reset outputs actual=%b expected=000",
               {pwm_out, period_start, period_mid});
    end
    // R11: program shadow registers while idle
    idle(1, 1'b1, 1'b0, 4);
    idle(1, 1'b1, 1'b1, 2);
    idle(2, 1'b0, 1'b0, 0);
    enable = 1'b1;
    period(4, 2, 2, "R1 R2 R8 R11", -1, 1'b0, 0);
    period(4, 2, 2, "R5", 1, 1'b1, 3);      // mid-period duty write ignored
    period(4, 3, 3, "R5", 5, 1'b1, 0);
    period(4, 0, 0, "R3", 2, 1'b1, 9);
    period(4, 9, 9, "R4", 6, 1'b1, 1);
    dual_update = 1'b1;
    period(4, 1, 4, "R6", 1, 1'b1, 4);      // second half picks up 4
    period(4, 4, 2, "R6", 3, 1'b1, 2);      // second half picks up 2
    dual_update = 1'b0;
    period(4, 2, 2, "R7", 2, 1'b0, 6);      // period write deferred
    period(6, 2, 2, "R7 R1", -1, 1'b0, 0);
    enable = 1'b0;
    idle(3, 1'b0, 1'b0, 0);
    enable = 1'b1;
    period(6, 2, 2, "R9", 3, 1'b0, 1);      // restart, then shortest period
    period(1, 2, 2, "R4 R8", -1, 1'b0, 0);
    period(1, 2, 2, "R8", -1, 1'b0, 0);
    enable = 1'b0;
    idle(2, 1'b0, 1'b0, 0);
    repeat (2) @(negedge clk);
    if (q_val.size() != 0) begin
      n_fails++;
      $display("FAIL R1: %0d expected items never compared (expected 0)",
               q_val.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fails++;
      $display("FAIL R1: watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule